// File: doc/BRIEF.md
# Multiplexed Bus Width Exchanger

This block links a single-word A port with a double-width B port. The B port is made of a low half and a high half, each one word wide. Data from A to B goes into two register banks, one per B half, clocked on the rising edge. Each bank has its own active-low capture enable. By opening the low bank's enable on one cycle and the high bank's on the next, two successive A words can be shown together as one double-width word on B.

Data from B to A goes through two level-sensitive latches, one per B half, with no clock. Each latch is transparent while its active-low latch control is low and holds its value while that control is high. A pick input chooses which latched half drives A.

Each port has an active-low output enable. Each three-state driver is modelled as a data vector plus a drive-enable flag, so the block contains no inout wires.

Top module: `bus_width_exchanger`

## Requirements
- R1: On a rising clk edge with `lo_cap_n` low, the low bank loads `a_in`. On a rising clk edge with `hi_cap_n` low, the high bank loads `a_in`. The banks drive `b_lo_out` and `b_hi_out` respectively.
- R2: A bank whose capture enable is high keeps its value across clock edges, whatever `a_in` does.
- R3: If one word is captured with only `lo_cap_n` low and the next word with only `hi_cap_n` low, the concatenation {`b_hi_out`, `b_lo_out`} shows the second word above the first.
- R4: While `lo_lat_n` (or `hi_lat_n`) is low, the matching latch follows `b_lo_in` (or `b_hi_in`) without any clock edge.
- R5: While a latch control is high, its latch holds its value, and changes on its B input have no effect on `a_out`.
- R6: `ret_pick` = 0 routes the low latch to `a_out`, and `ret_pick` = 1 routes the high latch to `a_out`.
- R7: `a_out_en` equals the inverse of `a_oe_n`, and `b_out_en` equals the inverse of `b_oe_n`. While a drive enable is 0, the data outputs of that port read all zeros.
- R8: `rst` is active high. A rising clk edge with `rst` high clears both banks to zero. While `rst` is high, both latches read zero and both drive enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the A-to-B banks |
| rst | input | 1 | Active-high reset |
| a_in | input | WORD_W | A-port data into the banks |
| a_oe_n | input | 1 | Active-low A-port output enable |
| lo_cap_n | input | 1 | Active-low capture enable, low bank |
| hi_cap_n | input | 1 | Active-low capture enable, high bank |
| b_oe_n | input | 1 | Active-low B-port output enable |
| b_lo_in | input | WORD_W | Low B half into its latch |
| b_hi_in | input | WORD_W | High B half into its latch |
| lo_lat_n | input | 1 | Low latch control, transparent when low |
| hi_lat_n | input | 1 | High latch control, transparent when low |
| ret_pick | input | 1 | Chooses the latch that drives A (0 low, 1 high) |
| a_out | output | WORD_W | A-port driven data |
| a_out_en | output | 1 | A-port drive enable (0 means high impedance) |
| b_lo_out | output | WORD_W | Low B half driven data |
| b_hi_out | output | WORD_W | High B half driven data |
| b_out_en | output | 1 | B-port drive enable (0 means high impedance) |

## Verification
On every clock edge, the assertions check bank capture and bank hold, latch transparency, routing of the low and high latches to A when that latch is open, zero data behind a disabled driver, and the drive enables held off during reset. Some behaviour only the bench scenarios can show. These are the staggered packing of two words into one B word, a latch holding through input changes between clock edges, and the values restored after a port is enabled again.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } pick_e;

  localparam int unsigned HALVES = 2;
endpackage

// File: rtl/bwx_capture_bank.sv
module bwx_capture_bank #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_n,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (!cap_n)
      q <= d;
  end

  AST_BANK_LOADS: assert property (@(posedge clk) disable iff (rst)
    !cap_n |=> (q == $past(d))); // R1
  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cap_n |=> $stable(q)); // R2
endmodule

// File: rtl/bwx_return_latch.sv
module bwx_return_latch #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_n,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_latch begin
    if (rst)
      q = '0;
    else if (!lat_n)
      q = d;
  end

  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
    !lat_n |-> (q == d)); // R4
endmodule

// File: rtl/bwx_port_gate.sv
module bwx_port_gate #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              en
);
  assign en = !oe_n && !rst;
  assign q  = en ? d : '0;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> (q == '0)); // R7
  AST_OFF_IN_RESET: assert property (@(posedge clk)
    rst |-> !en); // R8
endmodule

// File: rtl/bus_width_exchanger.sv
module bus_width_exchanger
  import bwx_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_in,
  input  logic              a_oe_n,
  input  logic              lo_cap_n,
  input  logic              hi_cap_n,
  input  logic              b_oe_n,
  input  logic [WORD_W-1:0] b_lo_in,
  input  logic [WORD_W-1:0] b_hi_in,
  input  logic              lo_lat_n,
  input  logic              hi_lat_n,
  input  logic              ret_pick,
  output logic [WORD_W-1:0] a_out,
  output logic              a_out_en,
  output logic [WORD_W-1:0] b_lo_out,
  output logic [WORD_W-1:0] b_hi_out,
  output logic              b_out_en
);
  localparam int unsigned WIDE_W = WORD_W * HALVES;

  logic [HALVES-1:0] cap_n_vec;
  logic [HALVES-1:0] lat_n_vec;
  logic [WORD_W-1:0] b_in_arr  [HALVES];
  logic [WORD_W-1:0] bank_q    [HALVES];
  logic [WORD_W-1:0] latch_q   [HALVES];
  logic [WORD_W-1:0] a_pick;
  logic [WIDE_W-1:0] b_wide;
  logic [WIDE_W-1:0] b_wide_gated;
  pick_e             pick;

  assign cap_n_vec  = {hi_cap_n, lo_cap_n};
  assign lat_n_vec  = {hi_lat_n, lo_lat_n};
  assign b_in_arr[0] = b_lo_in;
  assign b_in_arr[1] = b_hi_in;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    bwx_capture_bank #(.WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .cap_n (cap_n_vec[g]),
      .d     (a_in),
      .q     (bank_q[g])
    );
    bwx_return_latch #(.WORD_W(WORD_W)) u_latch (
      .clk   (clk),
      .rst   (rst),
      .lat_n (lat_n_vec[g]),
      .d     (b_in_arr[g]),
      .q     (latch_q[g])
    );
    assign b_wide[g*WORD_W +: WORD_W] = bank_q[g];
  end

  assign pick   = pick_e'(ret_pick);
  assign a_pick = (pick == PICK_HI) ? latch_q[1] : latch_q[0];

  bwx_port_gate #(.DATA_W(WORD_W)) u_a_gate (
    .clk  (clk),
    .rst  (rst),
    .oe_n (a_oe_n),
    .d    (a_pick),
    .q    (a_out),
    .en   (a_out_en)
  );

  bwx_port_gate #(.DATA_W(WIDE_W)) u_b_gate (
    .clk  (clk),
    .rst  (rst),
    .oe_n (b_oe_n),
    .d    (b_wide),
    .q    (b_wide_gated),
    .en   (b_out_en)
  );

  assign b_lo_out = b_wide_gated[WORD_W-1:0];
  assign b_hi_out = b_wide_gated[WIDE_W-1:WORD_W];

  AST_ROUTE_LO: assert property (@(posedge clk) disable iff (rst)
    (a_out_en && !ret_pick && !lo_lat_n) |-> (a_out == b_lo_in)); // R6
  AST_ROUTE_HI: assert property (@(posedge clk) disable iff (rst)
    (a_out_en && ret_pick && !hi_lat_n) |-> (a_out == b_hi_in)); // R6
endmodule

// File: tb/bus_width_exchanger_test.sv
module bus_width_exchanger_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in;
  logic         a_oe_n, lo_cap_n, hi_cap_n, b_oe_n;
  logic [W-1:0] b_lo_in, b_hi_in;
  logic         lo_lat_n, hi_lat_n, ret_pick;
  logic [W-1:0] a_out, b_lo_out, b_hi_out;
  logic         a_out_en, b_out_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_width_exchanger #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_oe_n(a_oe_n),
    .lo_cap_n(lo_cap_n), .hi_cap_n(hi_cap_n), .b_oe_n(b_oe_n),
    .b_lo_in(b_lo_in), .b_hi_in(b_hi_in), .lo_lat_n(lo_lat_n),
    .hi_lat_n(hi_lat_n), .ret_pick(ret_pick), .a_out(a_out),
    .a_out_en(a_out_en), .b_lo_out(b_lo_out), .b_hi_out(b_hi_out),
    .b_out_en(b_out_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; a_oe_n = 1'b0; b_oe_n = 1'b0;
    a_in = 12'hFFF; lo_cap_n = 1'b0; hi_cap_n = 1'b0;
    lo_lat_n = 1'b1; hi_lat_n = 1'b1; ret_pick = 1'b0;
    b_lo_in = 12'hAAA; b_hi_in = 12'h555;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 a drive off in reset", {31'd0, a_out_en}, 32'd0);
    chk("R8 b drive off in reset", {31'd0, b_out_en}, 32'd0);
    @(negedge clk);
    rst = 1'b0; lo_cap_n = 1'b1; hi_cap_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 banks cleared", {8'd0, b_hi_out, b_lo_out}, 32'd0);
    chk("R8 latch cleared", {20'd0, a_out}, 32'd0);
  endtask

  task automatic t_pack();
    @(negedge clk);
    a_in = 12'h123; lo_cap_n = 1'b0; hi_cap_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 low bank loads", {20'd0, b_lo_out}, 32'h123);
    chk("R2 high bank idle", {20'd0, b_hi_out}, 32'h0);
    @(negedge clk);
    a_in = 12'hABC; lo_cap_n = 1'b1; hi_cap_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 high bank loads", {20'd0, b_hi_out}, 32'hABC);
    chk("R3 packed wide word", {8'd0, b_hi_out, b_lo_out}, 32'h00ABC123);
    @(negedge clk);
    hi_cap_n = 1'b1;
  endtask

  task automatic t_bank_hold();
    @(negedge clk);
    a_in = 12'h555;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 banks hold", {8'd0, b_hi_out, b_lo_out}, 32'h00ABC123);
  endtask

  task automatic t_latch_pass();
    @(negedge clk);
    ret_pick = 1'b0; lo_lat_n = 1'b0; b_lo_in = 12'h3C3;
    #1;
    chk("R4 low latch passes", {20'd0, a_out}, 32'h3C3);
    b_lo_in = 12'h0F0;
    #1;
    chk("R4 low latch follows", {20'd0, a_out}, 32'h0F0);
  endtask

  task automatic t_latch_hold();
    lo_lat_n = 1'b1;
    #1;
    b_lo_in = 12'hFFF;
    #1;
    chk("R5 low latch holds", {20'd0, a_out}, 32'h0F0);
    repeat (2) @(posedge clk);
    #1;
    chk("R5 hold across clocks", {20'd0, a_out}, 32'h0F0);
  endtask

  task automatic t_pick();
    @(negedge clk);
    hi_lat_n = 1'b0; b_hi_in = 12'h7E7;
    #1;
    hi_lat_n = 1'b1;
    #1;
    b_hi_in = 12'h000;
    ret_pick = 1'b1;
    #1;
    chk("R6 pick high latch", {20'd0, a_out}, 32'h7E7);
    ret_pick = 1'b0;
    #1;
    chk("R6 pick low latch", {20'd0, a_out}, 32'h0F0);
  endtask

  task automatic t_disable();
    @(negedge clk);
    a_oe_n = 1'b1;
    #1;
    chk("R7 a enable off", {31'd0, a_out_en}, 32'd0);
    chk("R7 a data zero", {20'd0, a_out}, 32'd0);
    b_oe_n = 1'b1;
    #1;
    chk("R7 b enable off", {31'd0, b_out_en}, 32'd0);
    chk("R7 b data zero", {8'd0, b_hi_out, b_lo_out}, 32'd0);
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    #1;
    chk("R7 a restored", {19'd0, a_out_en, a_out}, 32'h10F0);
    chk("R7 b restored", {7'd0, b_out_en, b_hi_out, b_lo_out}, 32'h01ABC123);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_bank_hold();
    t_latch_pass();
    t_latch_hold();
    t_pick();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule